// File: doc/BRIEF.md
# Paging Frame Wake Scheduler

This block keeps track of where a synchronous time-slot paging receiver stands within the hourly broadcast schedule. The hour is split into 15 cycles of 128 frames each. A frame lasts 1.875 s, so 32 frames make one minute. The block counts frames on a frame-period tick, and it can be realigned at any time by a resynchronisation strobe that carries the frame and cycle numbers decoded from a frame header.

Each receiver is given a home frame and a collapse value. Together they choose the sparse subset of frames on which the receiver must power up its radio. The block raises a one-clock wake pulse on entry to each such frame. It also gives a one-minute pulse for the low-power timekeeping path and a flag at each hour boundary. A resync word that is out of range is dropped, and it latches an error flag.

Top module: `page_slot_sched`

## Requirements
- R1: `cur_frame` advances by one on each clock edge where `frame_tick` is high and no valid resync is present. It wraps from 127 to 0.
- R2: `cur_cycle` advances by one when a tick wraps the frame from 127 to 0. It wraps from 14 to 0. No other tick changes it.
- R3: With neither `frame_tick` nor `resync_stb` high, `cur_frame` and `cur_cycle` hold their values.
- R4: A resync is valid when `resync_frame` is at most 127 and `resync_cycle` is at most 14. A valid resync loads both counters on that edge. If a tick arrives on the same edge, the resync wins and the tick is dropped.
- R5: A resync with `resync_frame` above 127 or `resync_cycle` above 14 leaves the counters untouched. A tick on the same edge still advances them. The resync sets `resync_err`, which stays high until reset.
- R6: Let c be `collapse` (0 to 7). A frame f is a wake frame when f mod 2^c equals `base_frame` mod 2^c. `wake_pulse` is high for the one clock after the edge on which a tick or a valid resync enters a wake frame, and low otherwise.
- R7: `minute_pulse` is high for the one clock after the edge on which a tick enters frame 0, 32, 64 or 96. A resync never raises it.
- R8: `hour_start` is high for the one clock after the edge on which a tick or a valid resync brings the counters to cycle 0, frame 0.
- R9: During and after reset, `cur_frame` is 0, `cur_cycle` is 0, and `wake_pulse`, `minute_pulse`, `hour_start` and `resync_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-clock strobe at each frame boundary |
| resync_strobe | input | 1 | One-clock strobe: a decoded frame/cycle number is present |
| resync_frame | input | 8 | Decoded frame number (valid range 0..127) |
| resync_cycle | input | 4 | Decoded cycle number (valid range 0..14) |
| base_frame | input | 7 | Home frame of this receiver |
| collapse | input | 3 | Collapse value c: wake every 2^c frames |
| cur_frame | output | 7 | Current frame number |
| cur_cycle | output | 4 | Current cycle number |
| wake_pulse | output | 1 | One-clock pulse on entry to a wake frame |
| minute_pulse | output | 1 | One-clock pulse on entry to a frame that starts a minute |
| hour_start | output | 1 | One-clock pulse on reaching cycle 0, frame 0 |
| resync_err | output | 1 | Sticky flag: an out-of-range resync was seen |

## Verification
Two events can arrive on the same clock edge: a frame tick and a resync strobe. The bench drives both together with a valid resync word and checks that the loaded values win, that no minute pulse appears, and that the wake pulse reflects the loaded frame rather than the counted one. It then pairs a tick with an out-of-range resync and checks that the count still advances while the error flag latches.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int FRAMES_PER_CYCLE  = 128;
  localparam int CYCLES_PER_HOUR   = 15;
  localparam int FRAMES_PER_MINUTE = 32;

  localparam int FRAME_W    = $clog2(FRAMES_PER_CYCLE);
  localparam int CYCLE_W    = $clog2(CYCLES_PER_HOUR + 1);
  localparam int RS_FRAME_W = FRAME_W + 1;
  localparam int COLLAPSE_W = $clog2(FRAME_W + 1);
  localparam int MINUTE_W   = $clog2(FRAMES_PER_MINUTE);

  typedef logic [FRAME_W-1:0]    frame_t;
  typedef logic [CYCLE_W-1:0]    cycle_t;
  typedef logic [RS_FRAME_W-1:0] rs_frame_t;
  typedef logic [COLLAPSE_W-1:0] collapse_t;

  localparam frame_t    LAST_FRAME  = frame_t'(FRAMES_PER_CYCLE - 1);
  localparam cycle_t    LAST_CYCLE  = cycle_t'(CYCLES_PER_HOUR - 1);
  localparam rs_frame_t FRAME_LIMIT = rs_frame_t'(FRAMES_PER_CYCLE);

  function automatic frame_t frame_inc(frame_t f);
    return (f == LAST_FRAME) ? '0 : f + 1'b1;
  endfunction

  function automatic cycle_t cycle_inc(cycle_t c);
    return (c == LAST_CYCLE) ? '0 : c + 1'b1;
  endfunction

  // Low 'c' bits of frame and home frame must agree.
  function automatic logic wake_hit(frame_t f, frame_t home, collapse_t c);
    frame_t mask;
    mask = ~({FRAME_W{1'b1}} << c);
    return (f & mask) == (home & mask);
  endfunction

  function automatic logic minute_mark(frame_t f);
    return f[MINUTE_W-1:0] == '0;
  endfunction
endpackage

// File: rtl/pss_slot_counter.sv
module pss_slot_counter
  import pss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rs_stb,
  input  rs_frame_t rs_frame,
  input  cycle_t    rs_cycle,
  output frame_t    frame_q,
  output cycle_t    cycle_q,
  output frame_t    frame_nx,
  output cycle_t    cycle_nx,
  output logic      take_o,
  output logic      counted_o,
  output logic      bad_rs_o
);
  logic rs_ok;

  assign rs_ok    = rs_stb && (rs_frame < FRAME_LIMIT) && (rs_cycle <= LAST_CYCLE);
  assign bad_rs_o = rs_stb && !rs_ok;

  always_comb begin
    frame_nx  = frame_q;
    cycle_nx  = cycle_q;
    take_o    = 1'b0;
    counted_o = 1'b0;
    if (rs_ok) begin
      frame_nx = rs_frame[FRAME_W-1:0];
      cycle_nx = rs_cycle;
      take_o   = 1'b1;
    end else if (tick) begin
      frame_nx  = frame_inc(frame_q);
      cycle_nx  = (frame_q == LAST_FRAME) ? cycle_inc(cycle_q) : cycle_q;
      take_o    = 1'b1;
      counted_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      cycle_q <= '0;
    end else begin
      frame_q <= frame_nx;
      cycle_q <= cycle_nx;
    end
  end

  assert_cycle_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_q <= LAST_CYCLE);

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rs_stb) |=> (frame_q == frame_inc($past(frame_q))));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !rs_stb) |=> ($stable(frame_q) && $stable(cycle_q)));

  assert_resync_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_ok |=> (frame_q == $past(rs_frame[FRAME_W-1:0]) && cycle_q == $past(rs_cycle)));

  assert_bad_resync_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_rs_o && !tick) |=> ($stable(frame_q) && $stable(cycle_q)));
endmodule

// File: rtl/pss_event_reg.sv
module pss_event_reg
  import pss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      counted,
  input  logic      bad_rs,
  input  frame_t    frame_nx,
  input  cycle_t    cycle_nx,
  input  frame_t    home,
  input  collapse_t collapse,
  input  frame_t    frame_q,
  input  cycle_t    cycle_q,
  output logic      wake_q,
  output logic      minute_q,
  output logic      hour_q,
  output logic      err_q
);
  logic wake_ev, minute_ev, hour_ev;

  assign wake_ev   = take && wake_hit(frame_nx, home, collapse);
  assign minute_ev = counted && minute_mark(frame_nx);
  assign hour_ev   = take && (frame_nx == '0) && (cycle_nx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_q   <= 1'b0;
      minute_q <= 1'b0;
      hour_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      wake_q   <= wake_ev;
      minute_q <= minute_ev;
      hour_q   <= hour_ev;
      err_q    <= err_q | bad_rs;
    end
  end

  assert_wake_needs_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(take));

  assert_minute_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    minute_q |-> (frame_q[MINUTE_W-1:0] == '0));

  assert_hour_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hour_q |-> (frame_q == '0 && cycle_q == '0));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/page_slot_sched.sv
module page_slot_sched
  import pss_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_tick,
  input  logic                  resync_strobe,
  input  logic [RS_FRAME_W-1:0] resync_frame,
  input  logic [CYCLE_W-1:0]    resync_cycle,
  input  logic [FRAME_W-1:0]    base_frame,
  input  logic [COLLAPSE_W-1:0] collapse,
  output logic [FRAME_W-1:0]    cur_frame,
  output logic [CYCLE_W-1:0]    cur_cycle,
  output logic                  wake_pulse,
  output logic                  minute_pulse,
  output logic                  hour_start,
  output logic                  resync_err
);
  frame_t frame_nx;
  cycle_t cycle_nx;
  logic   slot_take, slot_counted, slot_bad_rs;

  pss_slot_counter counter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (frame_tick),
    .rs_stb    (resync_strobe),
    .rs_frame  (resync_frame),
    .rs_cycle  (resync_cycle),
    .frame_q   (cur_frame),
    .cycle_q   (cur_cycle),
    .frame_nx  (frame_nx),
    .cycle_nx  (cycle_nx),
    .take_o    (slot_take),
    .counted_o (slot_counted),
    .bad_rs_o  (slot_bad_rs)
  );

  pss_event_reg events_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (slot_take),
    .counted  (slot_counted),
    .bad_rs   (slot_bad_rs),
    .frame_nx (frame_nx),
    .cycle_nx (cycle_nx),
    .home     (base_frame),
    .collapse (collapse),
    .frame_q  (cur_frame),
    .cycle_q  (cur_cycle),
    .wake_q   (wake_pulse),
    .minute_q (minute_pulse),
    .hour_q   (hour_start),
    .err_q    (resync_err)
  );

  assert_pulses_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_tick) && !$past(resync_strobe)) |-> (!wake_pulse && !minute_pulse && !hour_start));
endmodule

// File: tb/page_slot_sched_tb_top.sv
module page_slot_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic       resync_strobe = 1'b0;
  logic [7:0] resync_frame = '0;
  logic [3:0] resync_cycle = '0;
  logic [6:0] base_frame = '0;
  logic [2:0] collapse = '0;
  logic [6:0] cur_frame;
  logic [3:0] cur_cycle;
  logic       wake_pulse, minute_pulse, hour_start, resync_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_frame = 0;
  int m_cycle = 0;
  int m_err   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_slot_sched dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .resync_strobe(resync_strobe),
    .resync_frame(resync_frame), .resync_cycle(resync_cycle), .base_frame(base_frame),
    .collapse(collapse), .cur_frame(cur_frame), .cur_cycle(cur_cycle),
    .wake_pulse(wake_pulse), .minute_pulse(minute_pulse), .hour_start(hour_start),
    .resync_err(resync_err)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int is_wake(int f, int b, int c);
    int span = 1 << c;
    return ((f % span) == (b % span)) ? 1 : 0;
  endfunction

  // Apply one clock edge with given inputs, model it, check all outputs afterwards.
  task automatic edge_step(int tk, int rs, int rf, int rc);
    int exp_wake = 0, exp_min = 0, exp_hour = 0;
    int ok;
    @(negedge clk);
    frame_tick    = tk[0];
    resync_strobe = rs[0];
    resync_frame  = rf[7:0];
    resync_cycle  = rc[3:0];
    ok = (rs != 0 && rf <= 127 && rc <= 14) ? 1 : 0;
    if (rs != 0 && ok == 0) m_err = 1;
    if (ok != 0) begin
      m_frame = rf; m_cycle = rc;
      exp_wake = is_wake(m_frame, base_frame, collapse);
      exp_hour = (m_frame == 0 && m_cycle == 0) ? 1 : 0;
    end else if (tk != 0) begin
      m_frame = m_frame + 1;
      if (m_frame == 128) begin
        m_frame = 0;
        m_cycle = (m_cycle == 14) ? 0 : m_cycle + 1;
      end
      exp_wake = is_wake(m_frame, base_frame, collapse);
      exp_min  = (m_frame % 32 == 0) ? 1 : 0;
      exp_hour = (m_frame == 0 && m_cycle == 0) ? 1 : 0;
    end
    @(negedge clk);
    frame_tick = 1'b0;
    resync_strobe = 1'b0;
    check("R1 frame", cur_frame, m_frame);
    check("R2 cycle", cur_cycle, m_cycle);
    check("R6 wake", wake_pulse, exp_wake);
    check("R7 minute", minute_pulse, exp_min);
    check("R8 hour", hour_start, exp_hour);
    check("R5 err", resync_err, m_err);
  endtask

  task automatic t_reset_R9();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 frame", cur_frame, 0);
    check("R9 cycle", cur_cycle, 0);
    check("R9 wake", wake_pulse, 0);
    check("R9 minute", minute_pulse, 0);
    check("R9 hour", hour_start, 0);
    check("R9 err", resync_err, 0);
    rst_n = 1'b1;
    m_frame = 0; m_cycle = 0; m_err = 0;
  endtask

  task automatic t_full_cycle_R1_R2();
    base_frame = 7'd5; collapse = 3'd3;
    for (int i = 0; i < 128; i++) edge_step(1, 0, 0, 0);
    check("R2 cycle after wrap", cur_cycle, 1);
  endtask

  task automatic t_idle_hold_R3();
    for (int i = 0; i < 4; i++) edge_step(0, 0, 0, 0);
  endtask

  task automatic t_hour_wrap_R8();
    edge_step(0, 1, 127, 14);
    edge_step(1, 0, 0, 0);
    check("R8 hour at wrap", hour_start, 1);
    edge_step(0, 1, 0, 0);
    check("R8 hour on resync", hour_start, 1);
    check("R7 no minute on resync", minute_pulse, 0);
  endtask

  task automatic t_collapse_R6();
    base_frame = 7'd77; collapse = 3'd7;
    edge_step(0, 1, 77, 3);
    check("R6 wake on home frame", wake_pulse, 1);
    edge_step(0, 1, 13, 3);
    check("R6 no wake off frame", wake_pulse, 0);
    edge_step(0, 1, 75, 3);
    edge_step(1, 0, 0, 0);
    edge_step(1, 0, 0, 0);
    collapse = 3'd0;
    for (int i = 0; i < 5; i++) edge_step(1, 0, 0, 0);
    collapse = 3'd1; base_frame = 7'd0;
    for (int i = 0; i < 4; i++) edge_step(1, 0, 0, 0);
  endtask

  task automatic t_collision_R4();
    base_frame = 7'd40; collapse = 3'd7;
    edge_step(0, 1, 30, 6);
    edge_step(1, 1, 40, 2);
    check("R4 resync wins frame", cur_frame, 40);
    check("R4 resync wins cycle", cur_cycle, 2);
    check("R4 wake from loaded frame", wake_pulse, 1);
    edge_step(1, 1, 63, 9);
    check("R4 no minute under resync", minute_pulse, 0);
  endtask

  task automatic t_bad_resync_R5();
    edge_step(1, 1, 200, 3);
    check("R5 tick still counts", cur_frame, 64);
    check("R5 err set", resync_err, 1);
    edge_step(0, 1, 10, 15);
    check("R5 counters untouched", cur_frame, 64);
    for (int i = 0; i < 6; i++) edge_step(1, 0, 0, 0);
    check("R5 err sticky", resync_err, 1);
  endtask

  initial begin
    t_reset_R9();
    t_full_cycle_R1_R2();
    t_idle_hold_R3();
    t_hour_wrap_R8();
    t_collapse_R6();
    t_collision_R4();
    t_bad_resync_R5();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule